// File: doc/BRIEF.md
# Nibble-Mode Reverse Byte Receiver

This block is the host side of a reverse-channel link that pulls bytes out of a peripheral four bits at a time over the printer-port status lines. It assumes the link has already agreed to use nibble mode. Once a transfer starts, the host asks for each nibble by pulling its auto-feed line low. The peripheral puts four status lines in place and drops its acknowledge line. The host latches the nibble, raises auto-feed to confirm, and waits for acknowledge to return high. Two such exchanges, low half first, make one byte.

A transfer starts with a one-cycle `start` pulse and a byte count. Finished bytes leave on a valid/ready output. While a byte waits there unaccepted, the receiver stops and keeps auto-feed high, so the peripheral is never asked for more data than can be held. Every transfer ends with a one-cycle `done_o` pulse carrying a status code and the number of bytes delivered.

The state machine has seven states. IDLE leads to REQ_LO on a start with a non-zero count, or straight to DONE on a zero count. REQ_LO leads to ACK_LO when acknowledge falls, with the low nibble captured. ACK_LO leads to REQ_HI when acknowledge rises. REQ_HI leads to ACK_HI when acknowledge falls, with the high nibble captured. ACK_HI leads to EMIT when acknowledge rises. EMIT leads back to REQ_LO when the byte is accepted and more bytes are owed, or to DONE when the count is reached. A timeout in REQ_LO, ACK_LO or REQ_HI leads to DONE with a timeout status. A timeout in ACK_HI leads to DONE with an I/O error. DONE always returns to IDLE after one cycle. The status lines pass through a synchroniser of `SYNC_STAGES` flops before the state machine sees them.

Top module: `nib_rev_rx`

## Requirements
- R1: After reset, `autofd_n_o` is 1, `byte_valid` is 0, `done_o` is 0, and `strobe_n_o` and `selectin_n_o` are 1.
- R2: `strobe_n_o` and `selectin_n_o` are 1 at all times. A nibble is requested by driving `autofd_n_o` to 0.
- R3: A nibble is captured as {busy_i, perror_i, select_i, fault_n_i}, so that fault_n_i goes to bit 0 and busy_i to bit 3. The first nibble of a byte becomes `byte_data[3:0]` and the second becomes `byte_data[7:4]`.
- R4: After capturing a nibble, the receiver returns `autofd_n_o` to 1. It does not request another nibble while `ack_n_i` is still low.
- R5: The wait for the first nibble of a byte is limited to `IDLE_CYCLES`. A first nibble that arrives later than `RESP_CYCLES` but within `IDLE_CYCLES` is accepted.
- R6: If no first nibble arrives within `IDLE_CYCLES`, the transfer ends with `done_status` = 2'd1 (timeout). `done_count` then equals the number of bytes already accepted.
- R7: A timeout of `RESP_CYCLES` while waiting for acknowledge to rise after the low nibble, or for the second nibble, ends the transfer with status 2'd1. The partial byte is not delivered.
- R8: If acknowledge does not rise within `RESP_CYCLES` after the high nibble, the transfer ends with status 2'd2 (I/O error). That byte is not delivered or counted.
- R9: While `byte_valid` is 1 and `byte_ready` is 0, `byte_valid` stays 1, `byte_data` stays unchanged and `autofd_n_o` stays 1.
- R10: After `req_count` bytes are accepted, `done_o` pulses for one cycle with status 2'd0 and `done_count` = `req_count`. A new transfer can then start.
- R11: A start with `req_count` = 0 ends immediately with status 2'd0 and count 0. `autofd_n_o` is never driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a transfer, taken in IDLE |
| req_count | input | CNT_W | Number of bytes to receive, sampled with start |
| ack_n_i | input | 1 | Peripheral acknowledge line, low marks a valid nibble |
| fault_n_i | input | 1 | Status line carried to nibble bit 0 |
| select_i | input | 1 | Status line carried to nibble bit 1 |
| perror_i | input | 1 | Status line carried to nibble bit 2 |
| busy_i | input | 1 | Status line carried to nibble bit 3 |
| autofd_n_o | output | 1 | Host request/acknowledge line, low requests a nibble |
| strobe_n_o | output | 1 | Held high |
| selectin_n_o | output | 1 | Held high |
| byte_data | output | 8 | Assembled byte |
| byte_valid | output | 1 | byte_data is available |
| byte_ready | input | 1 | Consumer accepts byte_data |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| done_status | output | 2 | 0 completed, 1 timeout, 2 I/O error |
| done_count | output | CNT_W | Bytes accepted in the current or last transfer |

## Verification
The hardest paths to reach are the three timeout exits. Each needs the peripheral to go silent at one exact step of one exact byte. The hardest of these is the hang on the final acknowledge release, which must give an I/O error rather than a timeout. The bench's peripheral model takes a byte index and a step number and freezes at that point: it either never answers the request or holds acknowledge low until well after expiry. The bench then checks the status code, that the partial byte never appears on the output, and that the next transfer runs cleanly. A delayed first nibble that falls between the two timeout limits tests that the long limit applies to the first nibble only.

// File: rtl/nrx_pkg.sv
package nrx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ_LO,
        S_ACK_LO,
        S_REQ_HI,
        S_ACK_HI,
        S_EMIT,
        S_DONE
    } nrx_state_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_TIMEOUT = 2'd1,
        ST_IOERR   = 2'd2
    } nrx_status_e;

    typedef struct packed {
        logic ack_n;
        logic busy;
        logic perror;
        logic select;
        logic fault_n;
    } nrx_pins_t;

    // Status-line to nibble mapping: fault_n is bit 0 and busy is bit 3.
    function automatic logic [3:0] nrx_pick_nibble(input nrx_pins_t p);
        return {p.busy, p.perror, p.select, p.fault_n};
    endfunction

endpackage

// File: rtl/nrx_sync.sv
module nrx_sync #(
    parameter int unsigned W       = 5,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];

    initial begin
        if (STAGES < 2) $error("nrx_sync needs at least two stages");
    end
endmodule

// File: rtl/nrx_timer.sv
module nrx_timer #(
    parameter int unsigned IDLE_CYCLES = 20000,
    parameter int unsigned RESP_CYCLES = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic use_idle,
    output logic expired
);
    localparam int unsigned MAX_LIM = (IDLE_CYCLES > RESP_CYCLES) ? IDLE_CYCLES : RESP_CYCLES;
    localparam int unsigned TW      = $clog2(MAX_LIM + 1);

    logic [TW-1:0] cnt_q;
    logic [TW-1:0] limit;

    assign limit   = use_idle ? TW'(IDLE_CYCLES) : TW'(RESP_CYCLES);
    assign expired = (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (restart)        cnt_q <= '0;
        else if (cnt_q < limit)  cnt_q <= cnt_q + TW'(1);
    end

    // R5: a freshly restarted wait can never report expiry on the next cycle
    a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !expired);

    initial begin
        if (IDLE_CYCLES < 2 || RESP_CYCLES < 2) $error("nrx_timer limits must be at least 2");
    end
endmodule

// File: rtl/nrx_assemble.sv
module nrx_assemble (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_lo,
    input  logic       load_hi,
    input  logic [3:0] nibble,
    output logic [7:0] byte_o
);
    localparam int unsigned HALVES = 2;
    localparam int unsigned HW     = 4;

    logic [HALVES-1:0] load_vec;
    assign load_vec = {load_hi, load_lo};

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic [HW-1:0] half_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         half_q <= '0;
            else if (load_vec[h]) half_q <= nibble;
        end
        assign byte_o[h*HW +: HW] = half_q;
    end

    // R3: the byte only changes on a nibble capture
    a_r3_hold_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_lo && !load_hi) |=> $stable(byte_o));
endmodule

// File: rtl/nrx_fsm.sv
module nrx_fsm
    import nrx_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] req_count,
    input  logic             ack_n_s,
    input  logic             tmo_expired,
    input  logic             byte_ready,
    output logic             tmo_restart,
    output logic             tmo_use_idle,
    output logic             load_lo,
    output logic             load_hi,
    output logic             autofd_n,
    output logic             byte_valid,
    output logic             done,
    output nrx_status_e      status,
    output logic [CNT_W-1:0] count
);
    nrx_state_e       state_q, state_d;
    nrx_status_e      status_q, status_d;
    logic [CNT_W-1:0] cnt_q, req_q;
    logic [CNT_W-1:0] cnt_nx;

    assign cnt_nx = cnt_q + CNT_W'(1);

    // next-state and capture strobes
    always_comb begin
        state_d  = state_q;
        status_d = status_q;
        load_lo  = 1'b0;
        load_hi  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    status_d = ST_OK;
                    state_d  = (req_count == '0) ? S_DONE : S_REQ_LO;
                end
            end
            S_REQ_LO: begin
                if (!ack_n_s) begin
                    load_lo = 1'b1;
                    state_d = S_ACK_LO;
                end else if (tmo_expired) begin
                    status_d = ST_TIMEOUT;
                    state_d  = S_DONE;
                end
            end
            S_ACK_LO: begin
                if (ack_n_s) begin
                    state_d = S_REQ_HI;
                end else if (tmo_expired) begin
                    status_d = ST_TIMEOUT;
                    state_d  = S_DONE;
                end
            end
            S_REQ_HI: begin
                if (!ack_n_s) begin
                    load_hi = 1'b1;
                    state_d = S_ACK_HI;
                end else if (tmo_expired) begin
                    status_d = ST_TIMEOUT;
                    state_d  = S_DONE;
                end
            end
            S_ACK_HI: begin
                if (ack_n_s) begin
                    state_d = S_EMIT;
                end else if (tmo_expired) begin
                    status_d = ST_IOERR;
                    state_d  = S_DONE;
                end
            end
            S_EMIT: begin
                if (byte_ready) state_d = (cnt_nx == req_q) ? S_DONE : S_REQ_LO;
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transfer bookkeeping that the outputs report
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= ST_OK;
            cnt_q    <= '0;
            req_q    <= '0;
        end else begin
            status_q <= status_d;
            if (state_q == S_IDLE && start) begin
                req_q <= req_count;
                cnt_q <= '0;
            end else if (state_q == S_EMIT && byte_ready) begin
                cnt_q <= cnt_nx;
            end
        end
    end

    // outputs decoded from the state register
    always_comb begin
        autofd_n     = 1'b1;
        byte_valid   = 1'b0;
        done         = 1'b0;
        tmo_use_idle = 1'b0;
        unique case (state_q)
            S_REQ_LO: begin
                autofd_n     = 1'b0;
                tmo_use_idle = 1'b1;
            end
            S_REQ_HI: autofd_n   = 1'b0;
            S_EMIT:   byte_valid = 1'b1;
            S_DONE:   done       = 1'b1;
            default:  ;
        endcase
    end

    assign tmo_restart = (state_d != state_q);
    assign status      = status_q;
    assign count       = cnt_q;

    // R10: completion is a single-cycle pulse
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: a clean finish reports exactly the requested count
    a_r10_ok_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status_q == ST_OK) |-> (cnt_q == req_q));

    // R9: an offered byte is not withdrawn
    a_r9_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_ready) |=> byte_valid);

    // R8: I/O error only comes from the final acknowledge wait
    a_r8_ioerr_source: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status_q == ST_IOERR) |-> ($past(state_q) == S_ACK_HI));

    // R6 / R7: timeout only comes from the earlier waits
    a_r6_timeout_source: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status_q == ST_TIMEOUT) |->
            ($past(state_q) == S_REQ_LO || $past(state_q) == S_ACK_LO || $past(state_q) == S_REQ_HI));

    // R4: the high-nibble request follows a released acknowledge
    a_r4_release_before_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_REQ_HI && $past(state_q) == S_ACK_LO) |-> $past(ack_n_s));
endmodule

// File: rtl/nib_rev_rx.sv
module nib_rev_rx
    import nrx_pkg::*;
#(
    parameter int unsigned IDLE_CYCLES = 20000,
    parameter int unsigned RESP_CYCLES = 600,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] req_count,
    input  logic             ack_n_i,
    input  logic             fault_n_i,
    input  logic             select_i,
    input  logic             perror_i,
    input  logic             busy_i,
    output logic             autofd_n_o,
    output logic             strobe_n_o,
    output logic             selectin_n_o,
    output logic [7:0]       byte_data,
    output logic             byte_valid,
    input  logic             byte_ready,
    output logic             done_o,
    output logic [1:0]       done_status,
    output logic [CNT_W-1:0] done_count
);
    localparam int unsigned PIN_W = $bits(nrx_pins_t);

    nrx_pins_t   pins_raw, pins_s;
    logic        tmo_restart, tmo_use_idle, tmo_expired;
    logic        load_lo, load_hi;
    nrx_status_e status;

    assign pins_raw = '{ack_n: ack_n_i, busy: busy_i, perror: perror_i,
                        select: select_i, fault_n: fault_n_i};

    nrx_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pins_raw),
        .q    (pins_s)
    );

    nrx_timer #(.IDLE_CYCLES(IDLE_CYCLES), .RESP_CYCLES(RESP_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmo_restart),
        .use_idle(tmo_use_idle),
        .expired (tmo_expired)
    );

    nrx_assemble u_asm (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_lo(load_lo),
        .load_hi(load_hi),
        .nibble (nrx_pick_nibble(pins_s)),
        .byte_o (byte_data)
    );

    nrx_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .req_count   (req_count),
        .ack_n_s     (pins_s.ack_n),
        .tmo_expired (tmo_expired),
        .byte_ready  (byte_ready),
        .tmo_restart (tmo_restart),
        .tmo_use_idle(tmo_use_idle),
        .load_lo     (load_lo),
        .load_hi     (load_hi),
        .autofd_n    (autofd_n_o),
        .byte_valid  (byte_valid),
        .done        (done_o),
        .status      (status),
        .count       (done_count)
    );

    assign done_status  = status;
    assign strobe_n_o   = 1'b1;
    assign selectin_n_o = 1'b1;

    // R9: a stalled byte keeps its value and the host asks for nothing
    a_r9_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_ready) |=> (autofd_n_o && $stable(byte_data)));

    // R3: a capture happens only while a request is out
    a_r3_capture_on_request: assert property (@(posedge clk) disable iff (!rst_n)
        (load_lo || load_hi) |-> !autofd_n_o);
endmodule

// File: tb/tb_nib_rev_rx.sv
module tb_nib_rev_rx;
    localparam int unsigned IDLE_T = 400;
    localparam int unsigned RESP_T = 40;
    localparam int unsigned CW     = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CW-1:0] req_count = '0;
    logic ack_n = 1'b1, fault_n = 1'b0, sel = 1'b0, perr = 1'b0, busy = 1'b0;
    logic autofd_n_o, strobe_n_o, selectin_n_o;
    logic [7:0] byte_data;
    logic byte_valid;
    logic byte_ready = 1'b0;
    logic done_o;
    logic [1:0] done_status;
    logic [CW-1:0] done_count;

    always #5 clk = ~clk;

    nib_rev_rx #(.IDLE_CYCLES(IDLE_T), .RESP_CYCLES(RESP_T), .CNT_W(CW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_count(req_count),
        .ack_n_i(ack_n), .fault_n_i(fault_n), .select_i(sel), .perror_i(perr), .busy_i(busy),
        .autofd_n_o(autofd_n_o), .strobe_n_o(strobe_n_o), .selectin_n_o(selectin_n_o),
        .byte_data(byte_data), .byte_valid(byte_valid), .byte_ready(byte_ready),
        .done_o(done_o), .done_status(done_status), .done_count(done_count)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // scoreboard queues: bytes the peripheral sends, bytes expected at the output
    logic [7:0] pq[$];
    logic [7:0] exp_q[$];

    // peripheral model controls
    int lo_dly = 3, hi_dly = 3;
    int hang_byte = -1, hang_stage = 0;
    int byte_idx = 0;
    bit hi_half = 1'b0;
    int r2_viol = 0, r2_seen = 0, r4_viol = 0;

    // consumer controls
    bit alt_ready = 1'b0, stall_mode = 1'b0;
    int stall_ctr = 0, stall_cycles = 0, r9_viol = 0;
    bit prev_stall = 1'b0;
    logic [7:0] prev_data = '0;
    bit low_seen = 1'b0;

    // driver task: queue a byte for the peripheral and, if it will arrive, for the monitor
    task automatic add_byte(input logic [7:0] b, input bit delivered);
        pq.push_back(b);
        if (delivered) exp_q.push_back(b);
    endtask

    task automatic clear_setup();
        pq.delete();
        exp_q.delete();
        byte_idx = 0; hi_half = 1'b0;
        hang_byte = -1; hang_stage = 0;
        lo_dly = 3; hi_dly = 3;
        r4_viol = 0; low_seen = 1'b0;
    endtask

    task automatic run_xfer(input int n, input int exp_cnt, input int exp_st, input string tag);
        @(negedge clk);
        req_count = CW'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (done_o !== 1'b1) @(negedge clk);
        chk(done_status == 2'(exp_st), {tag, " status"}, done_status, exp_st);
        chk(done_count == CW'(exp_cnt), {tag, " count"}, done_count, exp_cnt);
        @(negedge clk);
        chk(done_o == 1'b0, "R10 done pulse width", done_o, 0);
        repeat (RESP_T + 50) @(negedge clk);
        chk(exp_q.size() == 0, {tag, " undelivered bytes"}, exp_q.size(), 0);
        chk(r4_viol == 0, "R4 request while ack low", r4_viol, 0);
    endtask

    // peripheral model
    initial begin : periph
        logic [7:0] cur;
        logic [3:0] nib;
        cur = '0;
        forever begin
            @(negedge clk);
            if (autofd_n_o !== 1'b0 || rst_n !== 1'b1) continue;
            r2_seen++;
            if (strobe_n_o !== 1'b1 || selectin_n_o !== 1'b1) r2_viol++;
            if (!hi_half) cur = (pq.size() > 0) ? pq.pop_front() : 8'h00;
            nib = hi_half ? cur[7:4] : cur[3:0];
            if (hang_byte == byte_idx && hang_stage == (hi_half ? 2 : 1)) begin
                while (autofd_n_o === 1'b0) @(negedge clk);
                hi_half = 1'b0;
                continue;
            end
            repeat (hi_half ? hi_dly : lo_dly) @(negedge clk);
            {busy, perr, sel, fault_n} = nib;
            @(negedge clk);
            ack_n = 1'b0;
            while (autofd_n_o !== 1'b1) @(negedge clk);
            if (hi_half && hang_byte == byte_idx && hang_stage == 3) begin
                repeat (RESP_T + 20) @(negedge clk);
                ack_n = 1'b1;
                hi_half = 1'b0;
                continue;
            end
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                if (autofd_n_o !== 1'b1) r4_viol++;
            end
            ack_n = 1'b1;
            if (hi_half) byte_idx++;
            hi_half = !hi_half;
        end
    end

    // consumer and monitor: pops the scoreboard on each accepted byte
    always @(negedge clk) begin
        if (rst_n) begin
            if (autofd_n_o === 1'b0) low_seen = 1'b1;
            if (stall_mode) byte_ready = !(byte_valid && stall_ctr < 20);
            else if (alt_ready) byte_ready = ~byte_ready;
            else byte_ready = 1'b1;
            if (byte_valid && !byte_ready) begin
                stall_ctr++;
                stall_cycles++;
                if (autofd_n_o !== 1'b1 || (prev_stall && byte_data !== prev_data)) r9_viol++;
            end
            if (byte_valid && byte_ready) begin
                stall_ctr = 0;
                if (exp_q.size() == 0) chk(1'b0, "R3 unexpected byte", byte_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(byte_data == e, "R3 byte value", byte_data, e);
                end
            end
            prev_stall = byte_valid && !byte_ready;
            prev_data  = byte_data;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog act=hung exp=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : tests
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(autofd_n_o == 1'b1, "R1 autofd", autofd_n_o, 1);
        chk(byte_valid == 1'b0, "R1 valid", byte_valid, 0);
        chk(done_o == 1'b0, "R1 done", done_o, 0);
        chk(strobe_n_o == 1'b1, "R1 strobe", strobe_n_o, 1);
        chk(selectin_n_o == 1'b1, "R1 selectin", selectin_n_o, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3 / R10: basic four-byte transfer
        clear_setup();
        add_byte(8'h3C, 1); add_byte(8'h81, 1); add_byte(8'hE7, 1); add_byte(8'h12, 1);
        run_xfer(4, 4, 0, "R10 basic");
        chk(r2_viol == 0 && r2_seen > 0, "R2 request lines", r2_viol, 0);

        // R3: edge patterns with a toggling consumer
        clear_setup();
        alt_ready = 1'b1;
        add_byte(8'h00, 1); add_byte(8'hFF, 1); add_byte(8'hA5, 1);
        add_byte(8'h5A, 1); add_byte(8'h0F, 1); add_byte(8'hF0, 1);
        add_byte(8'h01, 1); add_byte(8'h80, 1);
        run_xfer(8, 8, 0, "R3 patterns");
        alt_ready = 1'b0;

        // R5: slow first nibble, beyond the short limit but inside the long one
        clear_setup();
        lo_dly = 100;
        add_byte(8'h6B, 1); add_byte(8'hC4, 1);
        run_xfer(2, 2, 0, "R5 slow first nibble");

        // R9: consumer stalls every byte
        clear_setup();
        stall_mode = 1'b1; stall_cycles = 0; r9_viol = 0;
        add_byte(8'h9D, 1); add_byte(8'h27, 1); add_byte(8'hB0, 1);
        run_xfer(3, 3, 0, "R9 stall");
        stall_mode = 1'b0;
        chk(r9_viol == 0, "R9 stall hold", r9_viol, 0);
        chk(stall_cycles >= 40, "R9 stall exercised", stall_cycles, 40);

        // R11: zero-length request
        clear_setup();
        run_xfer(0, 0, 0, "R11 zero count");
        chk(low_seen == 1'b0, "R11 no request", low_seen, 0);

        // R6: peripheral silent on the first nibble of byte 2
        clear_setup();
        hang_byte = 2; hang_stage = 1;
        add_byte(8'h11, 1); add_byte(8'h22, 1); add_byte(8'h33, 0); add_byte(8'h44, 0); add_byte(8'h55, 0);
        run_xfer(5, 2, 1, "R6 first nibble timeout");

        // R7: peripheral silent on the second nibble of byte 1
        clear_setup();
        hang_byte = 1; hang_stage = 2;
        add_byte(8'h7E, 1); add_byte(8'hD2, 0); add_byte(8'h48, 0);
        run_xfer(3, 1, 1, "R7 second nibble timeout");

        // R7: second nibble later than the short limit
        clear_setup();
        hi_dly = 80;
        add_byte(8'hAB, 0);
        run_xfer(1, 0, 1, "R7 slow second nibble");

        // R8: acknowledge stuck low after the high nibble of byte 1
        clear_setup();
        hang_byte = 1; hang_stage = 3;
        add_byte(8'hC3, 1); add_byte(8'h5F, 0); add_byte(8'h90, 0);
        run_xfer(3, 1, 2, "R8 final handshake");

        // R10: recovery after the error exits
        clear_setup();
        add_byte(8'h2D, 1); add_byte(8'hE1, 1);
        run_xfer(2, 2, 0, "R10 recovery");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule